// File: doc/BRIEF.md
# Self-Reloading DMA Channel Control

This block is the control side of a single DMA channel working in a self-reloading transfer mode. Software sets the channel enable. A sampled request pulse then sets a one-bit pending flag, and that flag raises a bus request. When the bus grant arrives, the flag drops and the channel is busy until the data path reports the end of the transfer with a one-cycle done strobe.

Each completed transfer counts the transfer counter down by one. A counter loaded with N gives N+1 transfers per round. When a transfer completes with the counter at zero, the counter refills from a separate reload register and the channel keeps running without software. The same event raises an interrupt-request flag. An interrupt acknowledge or a software clear removes that flag. Address generation, data movement and the bus protocol belong to neighbouring blocks.

Top module: `rpt_dma_chan`

## Requirements
- R1: After a synchronous reset the following are all 0: the enable, the pending flag, the bus request, the counter, the reload register and the interrupt flag.
- R2: A request pulse sampled while the channel is enabled sets the pending flag on the next cycle. While the flag is set and no transfer is in progress, bus_req is 1. The formula is bus_req = pending AND enable AND NOT busy.
- R3: A grant taken while bus_req is 1 clears the pending flag and makes the channel busy on the next cycle. bus_req stays 0 until the done strobe ends the transfer.
- R4: Several request pulses that arrive before the grant leave a single pending bit. They produce exactly one transfer.
- R5: A request sampled in the same cycle as an accepted grant sets the pending flag again, so that request is kept.
- R6: A done strobe while busy, with the counter not zero, lowers the counter by one. A counter loaded with N gives N+1 transfers before it refills.
- R7: A done strobe while busy, with the counter at zero, loads the counter from the reload register and sets the interrupt flag. The channel stays enabled and accepts further requests.
- R8: A write to the reload register leaves the counter unchanged. The new value is used only at the next underflow.
- R9: Either irq_ack or irq_sw_clr clears the interrupt flag. If an underflow occurs in the same cycle, the flag is set instead.
- R10: While the channel is disabled, request pulses leave the pending flag and bus_req at 0.
- R11: A software write to the counter is ignored while a transfer is in progress. It applies only when the channel is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_we | input | 1 | Strobe that writes the enable bit |
| en_wd | input | 1 | Value written to the enable bit |
| cnt_we | input | 1 | Strobe that writes the transfer counter |
| cnt_wd | input | CNT_W | Value written to the transfer counter |
| rld_we | input | 1 | Strobe that writes the reload register |
| rld_wd | input | CNT_W | Value written to the reload register |
| irq_ack | input | 1 | Interrupt acknowledge; clears the flag |
| irq_sw_clr | input | 1 | Software clear of the interrupt flag |
| req_in | input | 1 | Sampled transfer request pulse |
| bus_grant | input | 1 | Bus granted to this channel |
| xfer_done | input | 1 | One-cycle strobe at the end of a transfer |
| bus_req | output | 1 | Bus request |
| pend | output | 1 | Pending-request flag |
| busy | output | 1 | Transfer in progress |
| ch_en | output | 1 | Current enable bit |
| irq_flag | output | 1 | Interrupt-request flag |
| cnt_val | output | CNT_W | Current transfer counter |

## Verification
The bench targets four cases:

- **Request in the grant cycle.** A design that clears the pending flag last would lose this request.
- **Burst of requests before one grant.** A counting design would run extra transfers.
- **Underflow in the same cycle as an acknowledge.** A design that gives the clear priority would drop the new interrupt.
- **Reload and counter writes during a round or a transfer.** A design that copies the reload value at once would cut the round short, and one that lets a counter write through while busy would corrupt the count in flight.

It also checks that a full round takes N+1 transfers and that requests are ignored while the channel is disabled.

// File: rtl/rpt_dma_pkg.sv
package rpt_dma_pkg;
  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_BUSY = 1'b1
  } ch_state_e;

  localparam int unsigned DEF_CNT_W = 8;
endpackage

// File: rtl/dma_req_latch.sv
module dma_req_latch
  import rpt_dma_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ch_en,
  input  logic req_in,
  input  logic bus_grant,
  input  logic xfer_done,
  output logic pend,
  output logic busy,
  output logic bus_req,
  output logic xfer_start,
  output logic xfer_end
);
  ch_state_e state_q;
  logic      pend_q;
  logic      req_ok;

  assign req_ok     = req_in & ch_en;
  assign busy       = (state_q == CH_BUSY);
  assign bus_req    = pend_q & ch_en & ~busy;
  assign xfer_start = bus_grant & bus_req;
  assign xfer_end   = xfer_done & busy;
  assign pend       = pend_q;

  // A new request wins over the clear at grant, so it is never lost.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (req_ok) begin
      pend_q <= 1'b1;
    end else if (xfer_start) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CH_IDLE;
    end else begin
      case (state_q)
        CH_IDLE: if (xfer_start) state_q <= CH_BUSY;
        CH_BUSY: if (xfer_done)  state_q <= CH_IDLE;
        default: state_q <= CH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             xfer_end,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wd,
  input  logic             rld_we,
  input  logic [CNT_W-1:0] rld_wd,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rld_q,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  assign underflow = xfer_end & (cnt_q == CNT_ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      rld_q <= CNT_ZERO;
    end else if (rld_we) begin
      rld_q <= rld_wd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_ZERO;
    end else if (xfer_end) begin
      if (cnt_q == CNT_ZERO) cnt_q <= rld_q;
      else                   cnt_q <= cnt_q - CNT_ONE;
    end else if (cnt_we && !busy) begin
      cnt_q <= cnt_wd;
    end
  end
endmodule

// File: rtl/dma_irq_flag.sv
module dma_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_in,
  input  logic ack_in,
  input  logic clr_in,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (set_in) begin
      flag_q <= 1'b1;
    end else if (ack_in || clr_in) begin
      flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rpt_dma_chan.sv
module rpt_dma_chan
  import rpt_dma_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_we,
  input  logic             en_wd,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wd,
  input  logic             rld_we,
  input  logic [CNT_W-1:0] rld_wd,
  input  logic             irq_ack,
  input  logic             irq_sw_clr,
  input  logic             req_in,
  input  logic             bus_grant,
  input  logic             xfer_done,
  output logic             bus_req,
  output logic             pend,
  output logic             busy,
  output logic             ch_en,
  output logic             irq_flag,
  output logic [CNT_W-1:0] cnt_val
);
  logic             en_q;
  logic             xfer_start;
  logic             xfer_end;
  logic             underflow;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rld_q;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= 1'b0;
    else if (en_we) en_q <= en_wd;
  end

  dma_req_latch u_req (
    .clk        (clk),
    .rst        (rst),
    .ch_en      (en_q),
    .req_in     (req_in),
    .bus_grant  (bus_grant),
    .xfer_done  (xfer_done),
    .pend       (pend),
    .busy       (busy),
    .bus_req    (bus_req),
    .xfer_start (xfer_start),
    .xfer_end   (xfer_end)
  );

  dma_xfer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .xfer_end  (xfer_end),
    .cnt_we    (cnt_we),
    .cnt_wd    (cnt_wd),
    .rld_we    (rld_we),
    .rld_wd    (rld_wd),
    .cnt_q     (cnt_q),
    .rld_q     (rld_q),
    .underflow (underflow)
  );

  dma_irq_flag u_irq (
    .clk    (clk),
    .rst    (rst),
    .set_in (underflow),
    .ack_in (irq_ack),
    .clr_in (irq_sw_clr),
    .flag_q (irq_flag)
  );

  assign ch_en   = en_q;
  assign cnt_val = cnt_q;
endmodule

// File: rtl/rpt_dma_chk.sv
module rpt_dma_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en_we,
  input logic             ch_en,
  input logic             req_in,
  input logic             bus_grant,
  input logic             xfer_done,
  input logic             irq_ack,
  input logic             irq_sw_clr,
  input logic             cnt_we,
  input logic             rld_we,
  input logic             bus_req,
  input logic             pend,
  input logic             busy,
  input logic             irq_flag,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] rld_q
);
  p_grant_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_grant && bus_req && !(req_in && ch_en)) |=> (!pend && busy && !bus_req));

  p_req_at_grant_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_grant && bus_req && req_in && ch_en) |=> pend);

  p_req_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (req_in && ch_en) |=> pend);

  p_decrement_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && busy && cnt_val != '0) |=> (cnt_val == $past(cnt_val) - 1'b1));

  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && busy && cnt_val == '0) |=> (cnt_val == $past(rld_q) && irq_flag));

  p_rld_no_touch_r8: assert property (@(posedge clk) disable iff (rst)
    (rld_we && !cnt_we && !(xfer_done && busy)) |=> $stable(cnt_val));

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst)
    ((irq_ack || irq_sw_clr) && !(xfer_done && busy && cnt_val == '0)) |=> !irq_flag);

  p_disabled_r10: assert property (@(posedge clk) disable iff (rst)
    (!ch_en && !pend) |=> !pend);

  p_busy_cnt_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && !xfer_done) |=> $stable(cnt_val));
endmodule

bind rpt_dma_chan rpt_dma_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en_we      (en_we),
  .ch_en      (ch_en),
  .req_in     (req_in),
  .bus_grant  (bus_grant),
  .xfer_done  (xfer_done),
  .irq_ack    (irq_ack),
  .irq_sw_clr (irq_sw_clr),
  .cnt_we     (cnt_we),
  .rld_we     (rld_we),
  .bus_req    (bus_req),
  .pend       (pend),
  .busy       (busy),
  .irq_flag   (irq_flag),
  .cnt_val    (cnt_val),
  .rld_q      (rld_q)
);

// File: tb/sim_rpt_dma_chan.sv
`timescale 1ns/1ps
module sim_rpt_dma_chan;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          en_we, en_wd, cnt_we, rld_we, irq_ack, irq_sw_clr;
  logic          req_in, bus_grant, xfer_done;
  logic [CW-1:0] cnt_wd, rld_wd;
  logic          bus_req, pend, busy, ch_en, irq_flag;
  logic [CW-1:0] cnt_val;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rpt_dma_chan #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .en_we(en_we), .en_wd(en_wd),
    .cnt_we(cnt_we), .cnt_wd(cnt_wd), .rld_we(rld_we), .rld_wd(rld_wd),
    .irq_ack(irq_ack), .irq_sw_clr(irq_sw_clr), .req_in(req_in),
    .bus_grant(bus_grant), .xfer_done(xfer_done), .bus_req(bus_req),
    .pend(pend), .busy(busy), .ch_en(ch_en), .irq_flag(irq_flag),
    .cnt_val(cnt_val)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    en_we = 0; en_wd = 0; cnt_we = 0; cnt_wd = '0; rld_we = 0; rld_wd = '0;
    irq_ack = 0; irq_sw_clr = 0; req_in = 0; bus_grant = 0; xfer_done = 0;
  endtask

  // Advance one clock; inputs change and outputs are sampled 1 ns after the edge.
  task automatic tick();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic wr_en(input logic v);
    en_we = 1; en_wd = v; tick();
  endtask

  task automatic wr_cnt(input int v);
    cnt_we = 1; cnt_wd = CW'(v); tick();
  endtask

  task automatic wr_rld(input int v);
    rld_we = 1; rld_wd = CW'(v); tick();
  endtask

  task automatic one_xfer();
    req_in = 1; tick();
    bus_grant = 1; tick();
    xfer_done = 1; tick();
  endtask

  task automatic t_reset();
    rst = 1; idle_inputs();
    tick(); tick();
    rst = 0;
    chk("R1 ch_en", ch_en, 0);
    chk("R1 pend", pend, 0);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 cnt_val", cnt_val, 0);
    chk("R1 irq_flag", irq_flag, 0);
  endtask

  task automatic t_round();
    wr_rld(2); wr_cnt(2); wr_en(1);
    req_in = 1; tick();
    chk("R2 pend set", pend, 1);
    chk("R2 bus_req", bus_req, 1);
    bus_grant = 1; tick();
    chk("R3 pend cleared", pend, 0);
    chk("R3 busy", busy, 1);
    chk("R3 bus_req low while busy", bus_req, 0);
    xfer_done = 1; tick();
    chk("R6 count 2->1", cnt_val, 1);
    chk("R7 no irq before underflow", irq_flag, 0);
    one_xfer();
    chk("R6 count 1->0", cnt_val, 0);
    one_xfer();
    chk("R7 reload after N+1 transfers", cnt_val, 2);
    chk("R7 irq set", irq_flag, 1);
    chk("R7 still enabled", ch_en, 1);
    req_in = 1; tick();
    chk("R7 accepts request after reload", bus_req, 1);
    bus_grant = 1; tick();
    xfer_done = 1; irq_sw_clr = 1; tick();
    chk("R9 sw clear", irq_flag, 0);
  endtask

  task automatic t_burst();
    wr_cnt(5);
    req_in = 1; tick();
    req_in = 1; tick();
    req_in = 1; tick();
    chk("R4 single pend", pend, 1);
    bus_grant = 1; tick();
    xfer_done = 1; tick();
    chk("R4 one transfer only", cnt_val, 4);
    chk("R4 no pend left", pend, 0);
    chk("R4 no bus_req left", bus_req, 0);
  endtask

  task automatic t_req_at_grant();
    wr_cnt(5);
    req_in = 1; tick();
    bus_grant = 1; req_in = 1; tick();
    chk("R5 pend kept", pend, 1);
    chk("R5 busy", busy, 1);
    xfer_done = 1; tick();
    chk("R5 second request raised", bus_req, 1);
    bus_grant = 1; tick();
    xfer_done = 1; tick();
    chk("R5 two transfers", cnt_val, 3);
  endtask

  task automatic t_reload_write();
    wr_rld(1); wr_cnt(1);
    wr_rld(7);
    chk("R8 counter unchanged", cnt_val, 1);
    one_xfer();
    chk("R8 count continues", cnt_val, 0);
    one_xfer();
    chk("R8 new reload used", cnt_val, 7);
    irq_ack = 1; tick();
    chk("R9 ack clears", irq_flag, 0);
  endtask

  task automatic t_irq_race();
    wr_rld(3); wr_cnt(0);
    req_in = 1; tick();
    bus_grant = 1; tick();
    xfer_done = 1; irq_ack = 1; tick();
    chk("R9 set wins over ack", irq_flag, 1);
    irq_sw_clr = 1; tick();
    chk("R9 clear after race", irq_flag, 0);
  endtask

  task automatic t_busy_write();
    wr_cnt(4);
    req_in = 1; tick();
    bus_grant = 1; tick();
    cnt_we = 1; cnt_wd = 8'd9; tick();
    chk("R11 write ignored while busy", cnt_val, 4);
    xfer_done = 1; tick();
    chk("R11 decrement from old", cnt_val, 3);
    wr_cnt(9);
    chk("R11 write applies when idle", cnt_val, 9);
  endtask

  task automatic t_disabled();
    wr_en(0);
    req_in = 1; tick();
    req_in = 1; tick();
    chk("R10 pend stays 0", pend, 0);
    chk("R10 bus_req stays 0", bus_req, 0);
    chk("R10 count untouched", cnt_val, 9);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_round();
    t_burst();
    t_req_at_grant();
    t_reload_write();
    t_irq_race();
    t_busy_write();
    t_disabled();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule